// File: doc/BRIEF.md
# NAND Sector Hamming Parity Accumulator

This block folds the data of one 512-byte NAND sector into a set of paired odd and even parity bits. Every data bit has a bit address made of the beat index and the bit's position within the beat. Each parity pair follows one bit of that address. The odd member is the XOR of all data bits whose address bit is 1, and the even member covers the bits whose address bit is 0. Software later XORs the result with the parity stored in the spare area. If every pair then shows exactly one set bit, a single flipped bit is present, and the odd half of the syndrome spells out its address.

A pulse on `clear` starts a sector. It zeroes the parity and the beat counter and samples the bus width and the mode. Data beats marked with `valid` are then accumulated. There are three ways to feed the block. On an 8-bit bus, each beat is one byte, for 512 beats. On a 16-bit bus in byte mode, each beat is split into two bytes with the low byte first, for 256 beats. In 16-bit word mode, each beat is one word with a 4-bit column index, for 256 beats. The last accepted beat raises `done` for one cycle. The result then stays frozen until the next `clear`.

The controller is a three-state machine. IDLE waits after reset and goes to RUN on `clear`. RUN accumulates beats. It goes to HOLD when the final beat is accepted, and it restarts itself on `clear`. HOLD keeps the result and returns to RUN on `clear`.

Top module: `nand_parity_acc`

## Requirements
- R1: After reset `result` is 0 and `done` is 0. In IDLE, before any `clear`, beats have no effect on `result`.
- R2: `clear` zeroes `result` and the beat counter in the following cycle, even in the middle of a sector, and starts a new sector.
- R3: For a bit with address A, where A = beat*8 + bit position in byte mode on an 8-bit bus, pair k receives the data bit. The odd bit takes it if A[k] is 1 and the even bit takes it if A[k] is 0. A single set bit at address A therefore gives odd bits equal to A and even bits equal to ~A.
- R4: `result` is packed as {P2048o,P2048e,...,P2o,P2e,P1o,P1e}: bit 2k+1 is the odd bit of address bit k and bit 2k is the even bit.
- R5: In byte mode on a 16-bit bus, `data_in[7:0]` is byte 2w and `data_in[15:8]` is byte 2w+1 of beat w. A sector is 256 beats.
- R6: In word mode, address A = word*16 + bit position (0 to 15). The sector is 256 beats, and P1 to P8 follow the column bits.
- R7: Cycles with `valid` low leave `result` and the beat count unchanged.
- R8: `done` is 1 for exactly one cycle, in the cycle after the edge that accepts the final beat of the sector.
- R9: After the sector completes, `result` stays stable and further beats are ignored until `clear`.
- R10: `bus16` and `word_mode` are sampled only at `clear`. Changing them inside a sector has no effect. On an 8-bit bus, `data_in[15:8]` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Start a sector: zero parity and counter, sample mode |
| bus16 | input | 1 | 1 when the data bus is 16 bits wide |
| word_mode | input | 1 | 1 selects 16-bit word computation (only with bus16) |
| valid | input | 1 | Data beat strobe |
| data_in | input | 16 | Data beat; only [7:0] used on an 8-bit bus |
| done | output | 1 | One-cycle pulse after the last beat of a sector |
| result | output | 24 | Packed odd/even parity pairs P1 to P2048 |

## Verification
The bench builds the block with its default 512-byte sector. At that size the full 12-bit address range is reachable, up to the P2048 pair, and all three feeding schemes can be compared against one bit-address reference model. Single-bit sectors at chosen addresses exercise each pair's odd/even decision and the low-byte-first ordering. Patterned sectors with gaps, mid-sector restarts and mode changes inside a sector reach the counter end points and the sampling of the mode at `clear`.

// File: rtl/nand_par_pkg.sv
package nand_par_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } par_state_e;
endpackage

// File: rtl/nand_par_ctrl.sv
module nand_par_ctrl
    import nand_par_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    localparam int CNT_W   = $clog2(SECTOR_BYTES),
    localparam int BEATS8  = SECTOR_BYTES,
    localparam int BEATS16 = SECTOR_BYTES / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             valid,
    input  logic             bus16,
    input  logic             word_mode,
    output logic             wide,
    output logic [CNT_W-1:0] cnt,
    output logic             accept,
    output logic             done
);
    par_state_e state_q, state_d;
    logic       last_beat;

    assign last_beat = wide ? (cnt == CNT_W'(BEATS16 - 1))
                            : (cnt == CNT_W'(BEATS8 - 1));
    assign accept    = (state_q == ST_RUN) && valid && !clear;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (clear) state_d = ST_RUN;
            ST_RUN: begin
                if (clear)                   state_d = ST_RUN;
                else if (valid && last_beat) state_d = ST_HOLD;
            end
            ST_HOLD: if (clear) state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            wide <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (clear) begin
                cnt  <= '0;
                wide <= bus16 | word_mode;
            end else if (accept) begin
                cnt <= cnt + 1'b1;
                if (last_beat) done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/nand_par_contrib.sv
module nand_par_contrib #(
    parameter int SECTOR_BYTES = 512,
    localparam int CNT_W  = $clog2(SECTOR_BYTES),
    localparam int ADDR_W = CNT_W + 3,
    localparam int RES_W  = 2 * ADDR_W
) (
    input  logic [15:0]      data_in,
    input  logic             wide,
    input  logic [CNT_W-1:0] cnt,
    output logic [RES_W-1:0] mask
);
    logic [ADDR_W-1:0] base;

    assign base = wide ? (ADDR_W'(cnt) << 4) : (ADDR_W'(cnt) << 3);

    always_comb begin : fold
        logic [ADDR_W-1:0] ai;
        mask = '0;
        ai   = '0;
        for (int i = 0; i < 16; i++) begin
            if (i < 8 || wide) begin
                ai = base | ADDR_W'(i);
                for (int k = 0; k < ADDR_W; k++) begin
                    if (ai[k]) mask[2*k+1] = mask[2*k+1] ^ data_in[i];
                    else       mask[2*k]   = mask[2*k]   ^ data_in[i];
                end
            end
        end
    end
endmodule

// File: rtl/nand_parity_acc.sv
module nand_parity_acc #(
    parameter int SECTOR_BYTES = 512,
    localparam int CNT_W  = $clog2(SECTOR_BYTES),
    localparam int ADDR_W = CNT_W + 3,
    localparam int RES_W  = 2 * ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bus16,
    input  logic             word_mode,
    input  logic             valid,
    input  logic [15:0]      data_in,
    output logic             done,
    output logic [RES_W-1:0] result
);
    logic             wide;
    logic             accept;
    logic [CNT_W-1:0] cnt;
    logic [RES_W-1:0] mask;

    nand_par_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clear(clear), .valid(valid),
        .bus16(bus16), .word_mode(word_mode), .wide(wide),
        .cnt(cnt), .accept(accept), .done(done)
    );

    nand_par_contrib #(.SECTOR_BYTES(SECTOR_BYTES)) u_contrib (
        .data_in(data_in), .wide(wide), .cnt(cnt), .mask(mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      result <= '0;
        else if (clear)  result <= '0;
        else if (accept) result <= result ^ mask;
    end
endmodule

// File: rtl/nand_parity_acc_chk.sv
module nand_parity_acc_chk #(
    parameter int RES_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear,
    input logic             valid,
    input logic             bus16,
    input logic             word_mode,
    input logic             done,
    input logic [RES_W-1:0] result
);
    // R8: the completion pulse lasts a single cycle
    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: a completion pulse follows an accepted beat
    a_r8_done_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(valid) && !$past(clear));

    // R2: clear empties the accumulator
    a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (result == '0));

    // R7: idle strobe leaves the parity untouched
    a_r7_no_valid_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !clear) |=> $stable(result));

    // R9: a finished sector is frozen
    a_r9_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> $stable(result));

    // R10: word computation needs the 16-bit bus when a sector starts
    a_r10_word_needs_bus16: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && word_mode) |-> bus16);
endmodule

bind nand_parity_acc nand_parity_acc_chk #(.RES_W(RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .valid(valid),
    .bus16(bus16), .word_mode(word_mode), .done(done), .result(result)
);

// File: tb/nand_parity_acc_tb.sv
module nand_parity_acc_tb;
    localparam int PERIOD = 10;
    localparam int NB     = 512;
    localparam int AW     = 12;
    localparam int RW     = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          bus16 = 1'b0;
    logic          word_mode = 1'b0;
    logic          valid = 1'b0;
    logic [15:0]   data_in = '0;
    logic          done;
    logic [RW-1:0] result;

    int checks = 0;
    int errors = 0;
    logic [7:0] sec [NB];

    nand_parity_acc u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .bus16(bus16),
        .word_mode(word_mode), .valid(valid), .data_in(data_in),
        .done(done), .result(result)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [RW-1:0] ref_par();
        logic [RW-1:0] r = '0;
        for (int n = 0; n < NB*8; n++) begin
            logic b = sec[n/8][n%8];
            for (int k = 0; k < AW; k++) begin
                if (n[k]) r[2*k+1] ^= b;
                else      r[2*k]   ^= b;
            end
        end
        return r;
    endfunction

    function automatic logic [RW-1:0] single_bit(input int a);
        logic [RW-1:0] r = '0;
        for (int k = 0; k < AW; k++) begin
            r[2*k+1] = a[k];
            r[2*k]   = ~a[k];
        end
        return r;
    endfunction

    task automatic fill_zero();
        for (int i = 0; i < NB; i++) sec[i] = 8'h00;
    endtask

    task automatic fill_pattern(input int seed);
        for (int i = 0; i < NB; i++) sec[i] = 8'(i*37 + seed + (i >> 3));
    endtask

    task automatic do_clear(input logic b16, input logic wm);
        @(negedge clk);
        clear = 1'b1; bus16 = b16; word_mode = wm; valid = 1'b0;
        @(negedge clk);
        clear = 1'b0;
    endtask

    // wide: 2 bytes per beat. gaps: idle cycle every third beat. flip: toggle bus16/word_mode mid-run
    task automatic run_sector(input string req, input logic b16, input logic wm,
                              input bit gaps, input bit flip);
        int beats = (b16 || wm) ? NB/2 : NB;
        int bad = 0;
        do_clear(b16, wm);
        for (int b = 0; b < beats; b++) begin
            if (gaps && (b % 3 == 0)) begin
                valid = 1'b0; data_in = 16'hFFFF;
                @(negedge clk);
                if (done !== 1'b0) bad++;
            end
            if (flip && b == 10) begin bus16 = ~b16; word_mode = ~wm & ~b16; end
            valid = 1'b1;
            if (b16 || wm) data_in = {sec[2*b+1], sec[2*b]};
            else           data_in = {8'(b*7+3), sec[b]};
            @(negedge clk);
            if (done !== ((b == beats-1) ? 1'b1 : 1'b0)) bad++;
        end
        valid = 1'b0;
        bus16 = b16; word_mode = wm;
        @(negedge clk);
        if (done !== 1'b0) bad++;
        check({req, " R8 done pulse"}, RW'(bad), '0);
        check(req, result, ref_par());
    endtask

    task automatic t_reset();
        check("R1 reset result", result, '0);
        check("R1 reset done", RW'(done), '0);
        @(negedge clk); valid = 1'b1; data_in = 16'hA5A5;
        repeat (3) @(negedge clk);
        valid = 1'b0;
        check("R1 idle ignores beats", result, '0);
    endtask

    task automatic t_single_bits();
        fill_zero(); run_sector("R3 R4 zero sector", 1'b0, 1'b0, 0, 0);
        fill_zero(); sec[300][5] = 1'b1;
        run_sector("R3 single bit byte8", 1'b0, 1'b0, 0, 0);
        check("R3 R4 syndrome address 2405", result, single_bit(300*8+5));
        fill_zero(); sec[511][7] = 1'b1;
        run_sector("R3 last bit", 1'b0, 1'b0, 0, 0);
        check("R3 R4 syndrome address 4095", result, single_bit(4095));
    endtask

    task automatic t_bus16_order();
        fill_zero(); sec[1][0] = 1'b1;
        run_sector("R5 high byte", 1'b1, 1'b0, 0, 0);
        check("R5 high byte is row 1", result, single_bit(8));
        fill_zero(); sec[0][0] = 1'b1;
        run_sector("R5 low byte", 1'b1, 1'b0, 0, 0);
        check("R5 low byte is row 0", result, single_bit(0));
    endtask

    task automatic t_patterns();
        fill_pattern(11); run_sector("R3 pattern byte8", 1'b0, 1'b0, 0, 0);
        fill_pattern(91); run_sector("R5 pattern bus16", 1'b1, 1'b0, 0, 0);
        fill_pattern(5);  run_sector("R6 pattern word16", 1'b1, 1'b1, 0, 0);
        fill_zero(); sec[201][6] = 1'b1;
        run_sector("R6 single bit word16", 1'b1, 1'b1, 0, 0);
        check("R6 column 14 word 100", result, single_bit(100*16+14));
    endtask

    task automatic t_gaps();
        fill_pattern(200); run_sector("R7 gaps byte8", 1'b0, 1'b0, 1, 0);
        fill_pattern(3);   run_sector("R7 gaps word16", 1'b1, 1'b1, 1, 0);
    endtask

    task automatic t_hold();
        logic [RW-1:0] snap = result;
        int dn = 0;
        for (int i = 0; i < 20; i++) begin
            valid = 1'b1; data_in = 16'(i*4099 + 1);
            @(negedge clk);
            if (done) dn++;
        end
        valid = 1'b0;
        check("R9 result held after sector", result, snap);
        check("R9 no further done", RW'(dn), '0);
    endtask

    task automatic t_restart();
        do_clear(1'b0, 1'b0);
        for (int b = 0; b < 100; b++) begin
            valid = 1'b1; data_in = 16'(b*13 + 7);
            @(negedge clk);
        end
        valid = 1'b0;
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
        check("R2 clear mid-sector zeroes", result, '0);
        fill_pattern(77); run_sector("R2 sector after restart", 1'b0, 1'b0, 0, 0);
    endtask

    task automatic t_mode_latch();
        fill_pattern(41); run_sector("R10 byte8 mode flipped mid-run", 1'b0, 1'b0, 0, 1);
        fill_pattern(58); run_sector("R10 bus16 mode flipped mid-run", 1'b1, 1'b0, 0, 1);
    endtask

    initial begin
        #(PERIOD*200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_bits();
        t_bus16_order();
        t_patterns();
        t_hold();
        t_gaps();
        t_restart();
        t_mode_latch();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule